// File: doc/BRIEF.md
# Sequential Instruction Fetch Unit

This block supplies a decode stage with a stream of 32-bit instruction words. The program counter counts whole words, not bytes. Each cycle the unit presents the program counter to a synchronous-read instruction memory. One cycle later it forwards the returned word to decode, together with that word's address plus one and a valid flag. Decode can steer the stream by raising a redirect with a target word address. The target becomes the next fetch address. The word already in flight from the memory is discarded.

The all-ones word acts as an end-of-program marker. When it comes back from memory, the unit does not forward it and stops issuing requests. From the following cycle it holds a sticky halted flag until reset. A marker word sitting in a slot that a redirect has discarded is never treated as the end of the program.

Top module: `fetch_unit`

## Requirements
- R1: While reset is low, out_valid and halted are low and imem_addr is 0. The first request after reset is to word address 0.
- R2: While fetching and without a redirect, imem_en is high and imem_addr advances by exactly one word each cycle.
- R3: The word that memory returns in the cycle after an address was presented appears on out_instr with out_valid high. In that same cycle out_next_pc equals that address plus one.
- R4: When redirect_valid is high in a fetching cycle, the next presented address is redirect_pc instead of the incremented address.
- R5: The word requested in the cycle of a redirect is discarded: out_valid is low in the following cycle.
- R6: A returned, non-discarded word equal to 32'hFFFFFFFF is not forwarded. In that cycle out_valid is low and imem_en is low.
- R7: halted rises in the cycle after the marker word returns and stays high until reset. While it is high, out_valid and imem_en stay low, and redirects leave imem_addr unchanged.
- R8: A marker word in a slot discarded by a redirect does not halt the unit. Fetching continues from the redirect target.
- R9: A reset applied while halted clears halted and restarts fetching from word address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_en | output | 1 | A fetch request is issued this cycle |
| imem_addr | output | AW | Word address presented to instruction memory |
| imem_rdata | input | XLEN | Word read from memory, valid the cycle after the request |
| redirect_valid | input | 1 | Decode requests a change of fetch address |
| redirect_pc | input | AW | Word address to fetch next on a redirect |
| out_valid | output | 1 | out_instr and out_next_pc carry a live instruction |
| out_instr | output | XLEN | Instruction word for decode |
| out_next_pc | output | AW | Address of out_instr plus one |
| halted | output | 1 | End-of-program marker seen; sticky until reset |

## Verification
The assertions assume the memory model has a read latency of exactly one cycle. They also assume the memory returns the word for whatever address was presented while imem_en was high. The bench models the memory as a clocked array that updates only on enabled cycles, which meets both assumptions. The bench drives redirect_valid and redirect_pc only at falling edges and holds them for whole cycles. Redirects are also applied while the unit is halted, to show that they have no effect there.

// File: rtl/fetch_pkg.sv
// Shared definitions for the instruction fetch unit.
// Assumes: instruction words default to 32 bits; the next-address selector
// is the only type exchanged between the fetch submodules.
package fetch_pkg;
    parameter int unsigned FETCH_XLEN = 32;

    typedef enum logic [1:0] {
        NEXT_SEQ  = 2'd0,
        NEXT_JUMP = 2'd1,
        NEXT_HOLD = 2'd2
    } next_sel_e;
endpackage

// File: rtl/fetch_pc_reg.sv
// Program counter register.
// Assumes: the selector is already prioritised by the caller
// (hold over jump over sequential). The counter wraps at 2**AW.
module fetch_pc_reg
    import fetch_pkg::*;
#(
    parameter int unsigned AW       = 16,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  next_sel_e     sel,
    input  logic [AW-1:0] jump_pc,
    output logic [AW-1:0] pc
);
    localparam logic [AW-1:0] PC_STEP = AW'(1);

    // Update the fetch address according to the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= RESET_PC;
        end else begin
            case (sel)
                NEXT_SEQ:  pc <= pc + PC_STEP;
                NEXT_JUMP: pc <= jump_pc;
                default:   pc <= pc;
            endcase
        end
    end
endmodule

// File: rtl/fetch_resp_track.sv
// Tracks the request in flight to the synchronous-read memory.
// Assumes: memory returns data exactly one cycle after a request.
// A squash marks the request of this cycle as dead.
module fetch_resp_track #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          squash,
    input  logic [AW-1:0] req_pc,
    output logic          resp_valid,
    output logic [AW-1:0] resp_next_pc
);
    localparam logic [AW-1:0] PC_STEP = AW'(1);

    logic [AW-1:0] resp_pc;

    // Record whether the returning word is live and where it came from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_pc    <= '0;
        end else begin
            resp_valid <= issue && !squash;
            if (issue) begin
                resp_pc <= req_pc;
            end
        end
    end

    // Sequential successor of the returning word.
    always_comb begin
        resp_next_pc = resp_pc + PC_STEP;
    end
endmodule

// File: rtl/fetch_halt_ctl.sv
// End-of-program detection and issue control.
// Assumes: the marker is the all-ones word. Only live (non-squashed)
// responses are inspected. Halt is sticky until reset.
module fetch_halt_ctl
    import fetch_pkg::*;
#(
    parameter int unsigned XLEN = FETCH_XLEN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            resp_valid,
    input  logic [XLEN-1:0] resp_word,
    input  logic            redirect_valid,
    output logic            issue,
    output logic            deliver,
    output next_sel_e       sel,
    output logic            halted
);
    localparam logic [XLEN-1:0] END_MARK = '1;

    logic marker_hit;

    // Classify the returning word and decide whether to keep fetching.
    always_comb begin
        marker_hit = resp_valid && (resp_word == END_MARK);
        issue      = !halted && !marker_hit;
        deliver    = resp_valid && !marker_hit && !halted;
    end

    // Choose the next address source: hold beats jump beats increment.
    always_comb begin
        if (!issue) begin
            sel = NEXT_HOLD;
        end else if (redirect_valid) begin
            sel = NEXT_JUMP;
        end else begin
            sel = NEXT_SEQ;
        end
    end

    // Sticky halt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
        end else begin
            halted <= halted || marker_hit;
        end
    end
endmodule

// File: rtl/fetch_unit.sv
// Top of the sequential instruction fetch unit.
// Fetches one word per cycle from a word-addressed memory with one-cycle
// read latency. It forwards each word with its successor address, accepts
// redirects from decode and halts on the all-ones marker word.
// Assumes: the memory honours imem_en and returns data on the next cycle.
module fetch_unit
    import fetch_pkg::*;
#(
    parameter int unsigned AW   = 16,
    parameter int unsigned XLEN = FETCH_XLEN
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            imem_en,
    output logic [AW-1:0]   imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    input  logic            redirect_valid,
    input  logic [AW-1:0]   redirect_pc,
    output logic            out_valid,
    output logic [XLEN-1:0] out_instr,
    output logic [AW-1:0]   out_next_pc,
    output logic            halted
);
    next_sel_e     sel;
    logic          issue;
    logic          deliver;
    logic          resp_valid;
    logic [AW-1:0] pc;
    logic [AW-1:0] resp_next_pc;

    fetch_pc_reg #(.AW(AW), .RESET_PC('0)) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .jump_pc (redirect_pc),
        .pc      (pc)
    );

    fetch_resp_track #(.AW(AW)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue        (issue),
        .squash       (redirect_valid),
        .req_pc       (pc),
        .resp_valid   (resp_valid),
        .resp_next_pc (resp_next_pc)
    );

    fetch_halt_ctl #(.XLEN(XLEN)) u_halt (
        .clk            (clk),
        .rst_n          (rst_n),
        .resp_valid     (resp_valid),
        .resp_word      (imem_rdata),
        .redirect_valid (redirect_valid),
        .issue          (issue),
        .deliver        (deliver),
        .sel            (sel),
        .halted         (halted)
    );

    // Drive the memory request and the decode-side outputs.
    always_comb begin
        imem_en     = issue;
        imem_addr   = pc;
        out_valid   = deliver;
        out_instr   = imem_rdata;
        out_next_pc = resp_next_pc;
    end
endmodule

// File: rtl/fetch_unit_chk.sv
// Property checker for fetch_unit, bound to every instance.
// Assumes one-cycle memory read latency.
module fetch_unit_chk #(
    parameter int unsigned AW   = 16,
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            imem_en,
    input logic [AW-1:0]   imem_addr,
    input logic [XLEN-1:0] imem_rdata,
    input logic            redirect_valid,
    input logic [AW-1:0]   redirect_pc,
    input logic            out_valid,
    input logic [XLEN-1:0] out_instr,
    input logic [AW-1:0]   out_next_pc,
    input logic            halted
);
    localparam logic [AW-1:0]   PC_STEP  = AW'(1);
    localparam logic [XLEN-1:0] END_MARK = '1;

    logic armed;

    // Marks cycles that have a full cycle of history since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_en && !redirect_valid) |=> (imem_addr == $past(imem_addr) + PC_STEP));

    p_next_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_next_pc == $past(imem_addr) + PC_STEP));

    p_redirect_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_en && redirect_valid) |=> (imem_addr == $past(redirect_pc)));

    p_squash_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_en && redirect_valid) |=> !out_valid);

    p_marker_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_instr != END_MARK));

    p_halt_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(imem_en) && !$past(redirect_valid) && !halted
         && imem_rdata == END_MARK) |=> halted);

    p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!out_valid && !imem_en));

    p_halt_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(imem_addr));
endmodule

bind fetch_unit fetch_unit_chk #(.AW(AW), .XLEN(XLEN)) u_fetch_unit_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .imem_en        (imem_en),
    .imem_addr      (imem_addr),
    .imem_rdata     (imem_rdata),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .out_valid      (out_valid),
    .out_instr      (out_instr),
    .out_next_pc    (out_next_pc),
    .halted         (halted)
);

// File: tb/fetch_unit_bench.sv
`timescale 1ns/1ps
// Directed bench for fetch_unit: one task per scenario.
module fetch_unit_bench;
    localparam int AW   = 16;
    localparam int XLEN = 32;
    localparam logic [XLEN-1:0] MARK = '1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            imem_en;
    logic [AW-1:0]   imem_addr;
    logic [XLEN-1:0] imem_rdata = '0;
    logic            redirect_valid = 1'b0;
    logic [AW-1:0]   redirect_pc = '0;
    logic            out_valid;
    logic [XLEN-1:0] out_instr;
    logic [AW-1:0]   out_next_pc;
    logic            halted;

    logic [XLEN-1:0] mem [0:255];
    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    fetch_unit #(.AW(AW), .XLEN(XLEN)) u_fetch_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .imem_en        (imem_en),
        .imem_addr      (imem_addr),
        .imem_rdata     (imem_rdata),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .out_valid      (out_valid),
        .out_instr      (out_instr),
        .out_next_pc    (out_next_pc),
        .halted         (halted)
    );

    always #10 clk = ~clk;

    // Synchronous-read instruction memory model.
    always @(posedge clk) begin
        if (imem_en) imem_rdata <= mem[imem_addr[7:0]];
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            failures = failures + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<=20000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 | i;
    endtask

    // Holds reset for a few cycles, checks the reset state (R1), releases at a falling edge.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        redirect_valid = 1'b0;
        redirect_pc = '0;
        repeat (3) tick();
        check(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 32'd0);
        check(halted == 1'b0, "R1", "halted in reset", 32'(halted), 32'd0);
        check(imem_addr == '0, "R1", "imem_addr in reset", 32'(imem_addr), 32'd0);
        rst_n = 1'b1;
    endtask

    // R2, R3: straight-line fetch.
    task automatic t_sequential();
        fill_mem();
        do_reset();
        for (int k = 1; k <= 20; k++) begin
            tick();
            check(out_valid == 1'b1, "R3", "out_valid seq", 32'(out_valid), 32'd1);
            check(out_instr == mem[k-1], "R3", "out_instr seq", out_instr, mem[k-1]);
            check(out_next_pc == AW'(k), "R3", "out_next_pc seq", 32'(out_next_pc), 32'(k));
            check(imem_addr == AW'(k), "R2", "imem_addr seq", 32'(imem_addr), 32'(k));
            check(imem_en == 1'b1, "R2", "imem_en seq", 32'(imem_en), 32'd1);
        end
    endtask

    // R4, R5: redirect wins over increment and squashes the in-flight word.
    task automatic t_redirect();
        fill_mem();
        do_reset();
        repeat (3) tick();
        check(out_instr == mem[2], "R3", "word before redirect", out_instr, mem[2]);
        redirect_valid = 1'b1;
        redirect_pc = AW'(40);
        tick();
        redirect_valid = 1'b0;
        check(imem_addr == AW'(40), "R4", "address after redirect", 32'(imem_addr), 32'd40);
        check(out_valid == 1'b0, "R5", "squashed slot", 32'(out_valid), 32'd0);
        tick();
        check(out_valid == 1'b1, "R4", "target valid", 32'(out_valid), 32'd1);
        check(out_instr == mem[40], "R4", "target word", out_instr, mem[40]);
        check(out_next_pc == AW'(41), "R4", "target next pc", 32'(out_next_pc), 32'd41);
        tick();
        check(out_instr == mem[41], "R2", "after target", out_instr, mem[41]);
    endtask

    // R6, R7, R9: end marker halts; redirects ignored; reset restarts.
    task automatic t_marker();
        fill_mem();
        mem[5] = MARK;
        do_reset();
        repeat (5) tick();
        check(out_instr == mem[4] && out_valid, "R3", "word before marker", out_instr, mem[4]);
        tick();
        check(out_valid == 1'b0, "R6", "marker not forwarded", 32'(out_valid), 32'd0);
        check(imem_en == 1'b0, "R6", "fetch stops on marker", 32'(imem_en), 32'd0);
        check(halted == 1'b0, "R7", "halt not yet", 32'(halted), 32'd0);
        tick();
        check(halted == 1'b1, "R7", "halt raised", 32'(halted), 32'd1);
        check(out_valid == 1'b0, "R7", "valid low halted", 32'(out_valid), 32'd0);
        redirect_valid = 1'b1;
        redirect_pc = AW'(2);
        repeat (3) tick();
        redirect_valid = 1'b0;
        check(halted == 1'b1, "R7", "halt sticky", 32'(halted), 32'd1);
        check(imem_addr == AW'(6), "R7", "redirect ignored", 32'(imem_addr), 32'd6);
        check(imem_en == 1'b0 && out_valid == 1'b0, "R7", "quiet while halted",
              {30'd0, imem_en, out_valid}, 32'd0);
        do_reset();
        check(halted == 1'b0, "R9", "reset clears halt", 32'(halted), 32'd0);
        tick();
        check(out_valid == 1'b1 && out_instr == mem[0], "R9", "restart at 0", out_instr, mem[0]);
    endtask

    // R8: marker in a squashed slot is ignored.
    task automatic t_squashed_marker();
        fill_mem();
        mem[3] = MARK;
        do_reset();
        repeat (3) tick();
        redirect_valid = 1'b1;
        redirect_pc = AW'(10);
        tick();
        redirect_valid = 1'b0;
        check(halted == 1'b0, "R8", "no halt from squashed", 32'(halted), 32'd0);
        check(imem_en == 1'b1, "R8", "still fetching", 32'(imem_en), 32'd1);
        tick();
        check(out_valid == 1'b1 && out_instr == mem[10], "R8", "target after squashed marker",
              out_instr, mem[10]);
        tick();
        check(halted == 1'b0, "R8", "still running", 32'(halted), 32'd0);
    endtask

    initial begin
        t_sequential();
        t_redirect();
        t_marker();
        t_squashed_marker();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule